// File: doc/BRIEF.md
# Fixed-Priority Single-Level Interrupt Controller

This block sits beside a small CPU core and turns four interrupt sources into one request strobe and one program-memory entry address. The sources are two external request pins (active low), an overflow event from the counter/timer, and a tick event from the fixed time-base timer. Each source keeps a pending state. A per-source enable and a master enable gate that state, and a fixed priority picks one winner whenever the core reaches an instruction boundary. The winner's 11-bit entry address is presented together with a registered request.

There is only one interrupt level. Once the core acknowledges a request, the controller enters its in-service state, and nothing further is offered until the core sends a return pulse. Each external pin can be set to latch a falling edge or to follow its low level. The latched flag of the source being taken is cleared on acknowledge. Enables and trigger modes are loaded through a single-cycle configuration strobe.

Top module: `fixed_prio_irq_ctrl`

## Requirements
- R1: A synchronous reset clears every pending flag, every enable (source and master), both trigger modes (to level) and the in-service state. After reset `irq_req` is 0, `irq_vector` is 0x000 and `in_service` is 0, and an event latched before the reset is not offered later.
- R2: When several enabled requests are pending, the winner is chosen in this fixed order, highest first: pin 0, counter/timer overflow, pin 1, time-base tick. In every mask below, bit i stands for source i of this order.
- R3: The entry addresses are 0x003 (pin 0), 0x00B (overflow), 0x013 (pin 1) and 0x01B (time-base). Each is 3 + 8 × priority index, 11 bits wide.
- R4: A source is offered only when its bit in `cfg_src_en` and the master enable `cfg_glob_en` are both loaded as 1. A disabled source still latches its event and is offered as soon as it is enabled.
- R5: In edge mode (`cfg_edge_mode` bit k = 1 for pin k), a high-to-low transition of the pin sets a flag that stays set after the pin rises. The flag is cleared when that source is acknowledged, and a pin held low does not request again.
- R6: In level mode (bit = 0), a pin requests exactly while it is low and nothing is latched. A request withdrawn before acknowledge leaves no trace, and a pin still low after the return requests again.
- R7: A one-cycle pulse on `ctr_ovf_evt` or `tbase_evt` sets that source's flag. The flag stays set until that source is acknowledged.
- R8: `irq_ack` while `irq_req` is 1 sets `in_service`. While `in_service` is 1, `irq_req` stays 0 whatever is pending.
- R9: `reti_pulse` clears `in_service` at the next edge. The next offer appears on `irq_req` one cycle after that, with the then-winning address.
- R10: Requests are offered only in cycles where `insn_boundary` is 1. `irq_req` and `irq_vector` are registered and change one cycle after the conditions that produce them.
- R11: `irq_ack` while `irq_req` is 0 has no effect on `in_service` or on any pending flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ext_pin_n | input | 2 | External request pins, active low; bit 0 is the higher-priority pin |
| ctr_ovf_evt | input | 1 | One-cycle overflow event from the counter/timer |
| tbase_evt | input | 1 | One-cycle tick event from the time-base timer |
| cfg_load | input | 1 | Loads the three configuration fields below |
| cfg_src_en | input | 4 | Per-source enables, bit i = priority index i |
| cfg_glob_en | input | 1 | Master enable |
| cfg_edge_mode | input | 2 | Trigger mode per pin, 1 = falling edge, 0 = low level |
| insn_boundary | input | 1 | Core is at an instruction boundary |
| irq_ack | input | 1 | Core takes the offered request |
| reti_pulse | input | 1 | One-cycle return-from-handler pulse |
| irq_req | output | 1 | Registered interrupt request to the core |
| irq_vector | output | 11 | Registered entry address of the offered source |
| in_service | output | 1 | A handler is running |

## Verification
The bench builds the block with its default parameters: an 11-bit address, base 3 and step 8. That is the only setting that yields the four fixed entry addresses, so every address check compares against them. A behavioural model in the bench follows pending flags, enables, the grant and the in-service state cycle by cycle. It is compared with the outputs on every clock. This covers simultaneous arrival of all four sources, level and edge pins held across acknowledge and return, disabled sources latched and released, and acknowledge without a request. Directed checks pin down the one-cycle latency after the boundary signal and after the return pulse.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
  localparam int NUM_SRC   = 4;
  localparam int SRC_IDX_W = $clog2(NUM_SRC);
  localparam int NUM_PINS  = 2;

  // priority index of each source: lower index wins
  typedef enum logic [SRC_IDX_W-1:0] {
    SRC_PIN0  = 2'd0,
    SRC_CTR   = 2'd1,
    SRC_PIN1  = 2'd2,
    SRC_TBASE = 2'd3
  } src_e;

  typedef struct packed {
    logic                glob_en;
    logic [NUM_SRC-1:0]  src_en;
    logic [NUM_PINS-1:0] edge_mode;
  } irq_cfg_t;
endpackage

// File: rtl/irqc_src_flag.sv
module irqc_src_flag (
  input  logic clk,
  input  logic rst,
  input  logic latch_mode,
  input  logic set_evt,
  input  logic level_req,
  input  logic clr,
  output logic pending
);
  logic flag_q;

  always_ff @(posedge clk) begin
    if (rst)              flag_q <= 1'b0;
    else if (!latch_mode) flag_q <= 1'b0;
    else if (set_evt)     flag_q <= 1'b1;
    else if (clr)         flag_q <= 1'b0;
  end

  assign pending = latch_mode ? flag_q : level_req;

  // latched event survives into the next cycle
  p_event_latched_r5: assert property (@(posedge clk) disable iff (rst)
    (latch_mode && set_evt) |=> flag_q);

  // an acknowledge without a new event drops the latched request
  p_clear_on_ack_r7: assert property (@(posedge clk) disable iff (rst)
    (latch_mode && clr && !set_evt) |=> !flag_q);
endmodule

// File: rtl/irqc_prio_pick.sv
module irqc_prio_pick #(
  parameter int N     = 4,
  parameter int IDX_W = $clog2(N)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [N-1:0]     req,
  output logic [N-1:0]     grant_oh,
  output logic [IDX_W-1:0] grant_idx,
  output logic             any_req
);
  genvar g;
  generate
    for (g = 0; g < N; g++) begin : g_oh
      if (g == 0) begin : g_top
        assign grant_oh[g] = req[g];
      end else begin : g_rest
        assign grant_oh[g] = req[g] & ~(|req[g-1:0]);
      end
    end
  endgenerate

  always_comb begin
    grant_idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) grant_idx = IDX_W'(i);
    end
  end

  assign any_req = |req;

  p_single_winner_r2: assert property (@(posedge clk) disable iff (rst)
    $onehot0(grant_oh) && (any_req == (grant_oh != '0)));

  p_winner_is_requester_r2: assert property (@(posedge clk) disable iff (rst)
    any_req |-> req[grant_idx]);
endmodule

// File: rtl/irqc_dispatch.sv
module irqc_dispatch #(
  parameter int N         = 4,
  parameter int IDX_W     = $clog2(N),
  parameter int VEC_W     = 11,
  parameter int VEC_BASE  = 3,
  parameter int VEC_STEP  = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             insn_boundary,
  input  logic             irq_ack,
  input  logic             reti_pulse,
  input  logic             any_req,
  input  logic [IDX_W-1:0] win_idx,
  output logic             irq_req,
  output logic [VEC_W-1:0] irq_vector,
  output logic             in_service,
  output logic [N-1:0]     clr_oh
);
  logic             req_q;
  logic [VEC_W-1:0] vec_q;
  logic [IDX_W-1:0] gnt_q;
  logic             svc_q;
  logic             ack_ok;
  logic             offer;
  logic [VEC_W-1:0] vec_next;

  assign ack_ok   = irq_ack & req_q;
  assign offer    = insn_boundary & ~svc_q & ~irq_ack & any_req;
  assign vec_next = VEC_W'(VEC_BASE + VEC_STEP * int'(win_idx));

  always_ff @(posedge clk) begin
    if (rst) begin
      req_q <= 1'b0;
      vec_q <= '0;
      gnt_q <= '0;
      svc_q <= 1'b0;
    end else begin
      req_q <= offer;
      if (offer) begin
        vec_q <= vec_next;
        gnt_q <= win_idx;
      end
      if (ack_ok)          svc_q <= 1'b1;
      else if (reti_pulse) svc_q <= 1'b0;
    end
  end

  genvar g;
  generate
    for (g = 0; g < N; g++) begin : g_clr
      assign clr_oh[g] = ack_ok && (gnt_q == IDX_W'(g));
    end
  endgenerate

  assign irq_req    = req_q;
  assign irq_vector = vec_q;
  assign in_service = svc_q;

  p_lockout_r8: assert property (@(posedge clk) disable iff (rst)
    svc_q |-> !req_q);

  p_ack_enters_service_r8: assert property (@(posedge clk) disable iff (rst)
    (irq_ack && req_q) |=> svc_q);

  p_return_leaves_service_r9: assert property (@(posedge clk) disable iff (rst)
    (reti_pulse && !(irq_ack && req_q)) |=> !svc_q);

  p_offer_at_boundary_r10: assert property (@(posedge clk) disable iff (rst)
    (!insn_boundary) |=> !req_q);

  p_stray_ack_ignored_r11: assert property (@(posedge clk) disable iff (rst)
    (irq_ack && !req_q && !svc_q) |=> !svc_q);
endmodule

// File: rtl/fixed_prio_irq_ctrl.sv
module fixed_prio_irq_ctrl
  import irqc_pkg::*;
#(
  parameter int VEC_W    = 11,
  parameter int VEC_BASE = 3,
  parameter int VEC_STEP = 8
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [NUM_PINS-1:0] ext_pin_n,
  input  logic                ctr_ovf_evt,
  input  logic                tbase_evt,
  input  logic                cfg_load,
  input  logic [NUM_SRC-1:0]  cfg_src_en,
  input  logic                cfg_glob_en,
  input  logic [NUM_PINS-1:0] cfg_edge_mode,
  input  logic                insn_boundary,
  input  logic                irq_ack,
  input  logic                reti_pulse,
  output logic                irq_req,
  output logic [VEC_W-1:0]    irq_vector,
  output logic                in_service
);
  irq_cfg_t            cfg_q;
  logic [NUM_PINS-1:0] pin_prev_q;
  logic [NUM_PINS-1:0] pin_fall;
  logic [NUM_SRC-1:0]  latch_mode;
  logic [NUM_SRC-1:0]  set_evt;
  logic [NUM_SRC-1:0]  level_req;
  logic [NUM_SRC-1:0]  pending;
  logic [NUM_SRC-1:0]  eligible;
  logic [NUM_SRC-1:0]  grant_oh;
  logic [NUM_SRC-1:0]  clr_oh;
  logic [SRC_IDX_W-1:0] win_idx;
  logic                any_req;

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_q      <= '0;
      pin_prev_q <= '1;
    end else begin
      pin_prev_q <= ext_pin_n;
      if (cfg_load) begin
        cfg_q.glob_en   <= cfg_glob_en;
        cfg_q.src_en    <= cfg_src_en;
        cfg_q.edge_mode <= cfg_edge_mode;
      end
    end
  end

  assign pin_fall = pin_prev_q & ~ext_pin_n;

  // map the four sources onto their priority slots
  always_comb begin
    latch_mode[SRC_PIN0]  = cfg_q.edge_mode[0];
    set_evt[SRC_PIN0]     = pin_fall[0];
    level_req[SRC_PIN0]   = ~ext_pin_n[0];
    latch_mode[SRC_CTR]   = 1'b1;
    set_evt[SRC_CTR]      = ctr_ovf_evt;
    level_req[SRC_CTR]    = 1'b0;
    latch_mode[SRC_PIN1]  = cfg_q.edge_mode[1];
    set_evt[SRC_PIN1]     = pin_fall[1];
    level_req[SRC_PIN1]   = ~ext_pin_n[1];
    latch_mode[SRC_TBASE] = 1'b1;
    set_evt[SRC_TBASE]    = tbase_evt;
    level_req[SRC_TBASE]  = 1'b0;
  end

  genvar g;
  generate
    for (g = 0; g < NUM_SRC; g++) begin : g_src
      irqc_src_flag u_flag (
        .clk        (clk),
        .rst        (rst),
        .latch_mode (latch_mode[g]),
        .set_evt    (set_evt[g]),
        .level_req  (level_req[g]),
        .clr        (clr_oh[g]),
        .pending    (pending[g])
      );
    end
  endgenerate

  assign eligible = pending & cfg_q.src_en & {NUM_SRC{cfg_q.glob_en}};

  irqc_prio_pick #(
    .N     (NUM_SRC),
    .IDX_W (SRC_IDX_W)
  ) u_pick (
    .clk       (clk),
    .rst       (rst),
    .req       (eligible),
    .grant_oh  (grant_oh),
    .grant_idx (win_idx),
    .any_req   (any_req)
  );

  irqc_dispatch #(
    .N        (NUM_SRC),
    .IDX_W    (SRC_IDX_W),
    .VEC_W    (VEC_W),
    .VEC_BASE (VEC_BASE),
    .VEC_STEP (VEC_STEP)
  ) u_disp (
    .clk           (clk),
    .rst           (rst),
    .insn_boundary (insn_boundary),
    .irq_ack       (irq_ack),
    .reti_pulse    (reti_pulse),
    .any_req       (any_req),
    .win_idx       (win_idx),
    .irq_req       (irq_req),
    .irq_vector    (irq_vector),
    .in_service    (in_service),
    .clr_oh        (clr_oh)
  );

  p_grant_enabled_r4: assert property (@(posedge clk) disable iff (rst)
    (grant_oh != '0) |-> (cfg_q.glob_en && ((grant_oh & cfg_q.src_en) == grant_oh)));

  p_master_gate_r4: assert property (@(posedge clk) disable iff (rst)
    (irq_req && !$past(cfg_load)) |-> cfg_q.glob_en);

  p_vector_on_grid_r3: assert property (@(posedge clk) disable iff (rst)
    irq_req |-> (irq_vector == VEC_W'(VEC_BASE) ||
                 irq_vector == VEC_W'(VEC_BASE + VEC_STEP) ||
                 irq_vector == VEC_W'(VEC_BASE + 2 * VEC_STEP) ||
                 irq_vector == VEC_W'(VEC_BASE + 3 * VEC_STEP)));

  p_level_not_latched_r6: assert property (@(posedge clk) disable iff (rst)
    (!cfg_q.edge_mode[0] && ext_pin_n[0]) |-> !grant_oh[SRC_PIN0]);
endmodule

// File: tb/fixed_prio_irq_ctrl_bench.sv
module fixed_prio_irq_ctrl_bench;
  localparam int CLK_PERIOD = 10;
  localparam int VEC_W      = 11;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic [1:0]       ext_pin_n = 2'b11;
  logic             ctr_ovf_evt = 1'b0;
  logic             tbase_evt = 1'b0;
  logic             cfg_load = 1'b0;
  logic [3:0]       cfg_src_en = 4'h0;
  logic             cfg_glob_en = 1'b0;
  logic [1:0]       cfg_edge_mode = 2'b00;
  logic             insn_boundary = 1'b1;
  logic             irq_ack = 1'b0;
  logic             reti_pulse = 1'b0;
  logic             irq_req;
  logic [VEC_W-1:0] irq_vector;
  logic             in_service;

  int n_chk  = 0;
  int n_fail = 0;
  int cyc    = 0;
  bit done   = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  fixed_prio_irq_ctrl u_fixed_prio_irq_ctrl (
    .clk(clk), .rst(rst), .ext_pin_n(ext_pin_n), .ctr_ovf_evt(ctr_ovf_evt),
    .tbase_evt(tbase_evt), .cfg_load(cfg_load), .cfg_src_en(cfg_src_en),
    .cfg_glob_en(cfg_glob_en), .cfg_edge_mode(cfg_edge_mode),
    .insn_boundary(insn_boundary), .irq_ack(irq_ack), .reti_pulse(reti_pulse),
    .irq_req(irq_req), .irq_vector(irq_vector), .in_service(in_service)
  );

  // ---------------- behavioural reference model ----------------
  bit m_valid = 0;
  bit m_pinhist[2];
  bit m_flag[4];
  bit m_en[4];
  bit m_glob;
  bit m_edge[2];
  bit m_svc;
  bit m_req;
  int m_vec;
  int m_gid;

  function automatic int entry_of(int idx);
    return 3 + 8 * idx;
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      m_valid = 1;
      foreach (m_flag[i]) begin m_flag[i] = 0; m_en[i] = 0; end
      m_pinhist[0] = 1; m_pinhist[1] = 1;
      m_edge[0] = 0; m_edge[1] = 0;
      m_glob = 0; m_svc = 0; m_req = 0; m_vec = 0; m_gid = 0;
    end else begin
      bit pend[4];
      bit lowpin[2];
      bit taken;
      bit nreq;
      int win;
      lowpin[0] = !ext_pin_n[0];
      lowpin[1] = !ext_pin_n[1];
      pend[0] = m_edge[0] ? m_flag[0] : lowpin[0];
      pend[1] = m_flag[1];
      pend[2] = m_edge[1] ? m_flag[2] : lowpin[1];
      pend[3] = m_flag[3];
      win = -1;
      for (int i = 3; i >= 0; i--)
        if (pend[i] && m_en[i] && m_glob) win = i;
      taken = irq_ack && m_req;
      nreq = insn_boundary && !m_svc && !irq_ack && (win >= 0);
      // pins: source slots 0 and 2
      for (int k = 0; k < 2; k++) begin
        int s;
        s = 2 * k;
        if (!m_edge[k]) m_flag[s] = 0;
        else if (m_pinhist[k] && lowpin[k]) m_flag[s] = 1;
        else if (taken && m_gid == s) m_flag[s] = 0;
      end
      if (ctr_ovf_evt) m_flag[1] = 1;
      else if (taken && m_gid == 1) m_flag[1] = 0;
      if (tbase_evt) m_flag[3] = 1;
      else if (taken && m_gid == 3) m_flag[3] = 0;
      if (taken) m_svc = 1;
      else if (reti_pulse) m_svc = 0;
      if (nreq) begin m_vec = entry_of(win); m_gid = win; end
      m_req = nreq;
      m_pinhist[0] = ext_pin_n[0];
      m_pinhist[1] = ext_pin_n[1];
      if (cfg_load) begin
        for (int i = 0; i < 4; i++) m_en[i] = cfg_src_en[i];
        m_glob = cfg_glob_en;
        m_edge[0] = cfg_edge_mode[0];
        m_edge[1] = cfg_edge_mode[1];
      end
    end
  end

  always @(negedge clk) begin
    if (m_valid && !done) begin
      n_chk++;
      if (irq_req !== m_req || irq_vector !== VEC_W'(m_vec) || in_service !== m_svc) begin
        n_fail++;
        $display("FAIL R2/R3/R8 model compare @%0d: req=%0b vec=%03h svc=%0b exp req=%0b vec=%03h svc=%0b",
                 cyc, irq_req, irq_vector, in_service, m_req, m_vec[VEC_W-1:0], m_svc);
      end
    end
  end

  // ---------------- helpers ----------------
  task automatic chk(input string tag, input int got, input int exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %0h expected %0h", tag, got, exp);
    end
  endtask

  task automatic cycles(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic configure(input logic [3:0] en, input logic glob, input logic [1:0] edg);
    @(negedge clk);
    cfg_load = 1; cfg_src_en = en; cfg_glob_en = glob; cfg_edge_mode = edg;
    @(negedge clk);
    cfg_load = 0;
  endtask

  task automatic wait_req(input int max, output bit seen);
    seen = 0;
    for (int i = 0; i < max && !seen; i++) begin
      @(negedge clk);
      if (irq_req) seen = 1;
    end
  endtask

  task automatic take();
    irq_ack = 1;
    @(negedge clk);
    irq_ack = 0;
  endtask

  task automatic give_back();
    reti_pulse = 1;
    @(negedge clk);
    reti_pulse = 0;
  endtask

  task automatic quiet(input string tag, input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      chk(tag, irq_req, 0);
    end
  endtask

  task automatic expect_entry(input string tag, input int exp);
    bit seen;
    wait_req(10, seen);
    chk({tag, " request"}, seen, 1);
    chk({tag, " address"}, irq_vector, exp);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1;
    cycles(2);
    rst = 0;
    @(negedge clk);
  endtask

  // ---------------- watchdog ----------------
  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000 && !done) begin
      done = 1;
      n_chk++; n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
    end
  end

  // ---------------- stimulus ----------------
  initial begin
    cycles(3);
    rst = 0;
    @(negedge clk);
    chk("R1 reset req", irq_req, 0);
    chk("R1 reset vector", irq_vector, 0);
    chk("R1 reset service", in_service, 0);

    // all four at once, both pins edge mode
    configure(4'hF, 1, 2'b11);
    ext_pin_n = 2'b00; ctr_ovf_evt = 1; tbase_evt = 1;
    @(negedge clk);
    ctr_ovf_evt = 0; tbase_evt = 0;
    expect_entry("R2 R5 pin0 first", 'h003);
    take();
    chk("R8 in service after ack", in_service, 1);
    quiet("R8 lockout", 5);
    give_back();
    chk("R9 service cleared", in_service, 0);
    chk("R9 req one cycle later", irq_req, 0);
    @(negedge clk);
    chk("R9 re-offer", irq_req, 1);
    chk("R3 R7 overflow entry", irq_vector, 'h00B);
    take(); give_back();
    expect_entry("R2 pin1 third", 'h013);
    take(); give_back();
    expect_entry("R7 time-base last", 'h01B);
    take(); give_back();
    quiet("R5 held-low edge pins", 6);
    ext_pin_n = 2'b11;

    // disabled source still latches
    configure(4'b1101, 1, 2'b11);
    ctr_ovf_evt = 1; @(negedge clk); ctr_ovf_evt = 0;
    quiet("R4 source disabled", 5);
    configure(4'hF, 1, 2'b11);
    expect_entry("R4 latched while disabled", 'h00B);
    take(); give_back();

    // master enable
    configure(4'hF, 0, 2'b11);
    tbase_evt = 1; @(negedge clk); tbase_evt = 0;
    quiet("R4 master off", 5);
    configure(4'hF, 1, 2'b11);
    expect_entry("R4 master on", 'h01B);
    take(); give_back();

    // level mode on pin 1, boundary gating
    configure(4'hF, 1, 2'b01);
    insn_boundary = 0;
    ext_pin_n[1] = 0;
    quiet("R10 no boundary", 4);
    ext_pin_n[1] = 1;
    insn_boundary = 1;
    quiet("R6 withdrawn level", 4);
    ext_pin_n[1] = 0;
    expect_entry("R6 level low", 'h013);
    take(); give_back();
    expect_entry("R6 still low after return", 'h013);
    take();
    ext_pin_n[1] = 1;
    give_back();
    quiet("R6 released", 5);

    // stray acknowledge
    irq_ack = 1; @(negedge clk); irq_ack = 0;
    @(negedge clk);
    chk("R11 stray ack service", in_service, 0);
    configure(4'hF, 1, 2'b11);
    ctr_ovf_evt = 1; @(negedge clk); ctr_ovf_evt = 0;
    expect_entry("R11 later request normal", 'h00B);
    take(); give_back();

    // exact latency after boundary
    insn_boundary = 0;
    tbase_evt = 1; @(negedge clk); tbase_evt = 0;
    quiet("R10 held off", 3);
    insn_boundary = 1;
    @(negedge clk);
    chk("R10 one-cycle latency", irq_req, 1);
    chk("R10 address", irq_vector, 'h01B);
    take(); give_back();

    // reset discards latched event
    configure(4'b1101, 1, 2'b11);
    ctr_ovf_evt = 1; @(negedge clk); ctr_ovf_evt = 0;
    do_reset();
    chk("R1 reset req again", irq_req, 0);
    chk("R1 reset service again", in_service, 0);
    configure(4'hF, 1, 2'b11);
    quiet("R1 pending cleared", 5);

    cycles(2);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end
endmodule